// File: doc/BRIEF.md
# DMA Channel Trigger Front End

This block sits in front of one channel of a DMA engine and decides when that channel asks for service. A programmable selector picks one line out of a bank of peripheral event inputs. Rising edges on that line are latched into a sticky pending flag. Software can also set the flag (force) or drop it (clear). If a second trigger lands while the first is still waiting, a sticky overflow flag is raised, and that flag can drive an interrupt.

The channel holds its own run status, which software sets with a run command and drops with a halt command. A soft-reset command returns the channel to idle. While the channel is running and a trigger is pending, the block raises a start request to the transfer sequencer. The sequencer answers with a one-cycle acknowledge when the burst begins, and that acknowledge consumes the pending trigger.

Register access is reduced to two write strobes. One strobe loads the configuration fields. The other strobe carries the one-shot command bits, each of which acts only when written as 1.

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset, pend_flag, ovf_flag, ovf_irq, run_sts and start_req are all 0.
- R2: When cfg_sel = k (k ≠ 0) and cfg_trig_en = 1 were loaded, a 0-to-1 change on evt_in[k] sets pend_flag at the next clock edge. Lines other than evt_in[k] have no effect.
- R3: Selector value 0 means no peripheral. With cfg_sel = 0, no event line sets pend_flag, including evt_in[0]. Only a force command can set it.
- R4: While the loaded trigger-enable is 0, edges on the selected line leave pend_flag unchanged.
- R5: Triggers are edge-based. A selected line that stays high counts as one trigger, so it cannot cause an overflow.
- R6: A command write with cmd_force = 1 sets pend_flag exactly as an event does. A command write with cmd_clear = 1 clears pend_flag, and clear wins over a trigger in the same cycle. Bits written as 0 have no effect.
- R7: A trigger that arrives while pend_flag = 1 sets ovf_flag, unless the same cycle carries a sequencer acknowledge or a clear. ovf_irq equals ovf_flag gated by the loaded overflow-interrupt enable.
- R8: cmd_err_clr = 1 clears ovf_flag. A new overflow in the same cycle wins, and ovf_flag stays 1.
- R9: cmd_run = 1 sets run_sts. cmd_halt = 1 clears run_sts. When both are written together, halt wins.
- R10: start_req is 1 exactly when run_sts = 1 and pend_flag = 1. seq_ack clears pend_flag. A trigger in the same cycle as seq_ack leaves pend_flag at 1 without raising an overflow.
- R11: cmd_soft_rst = 1 clears pend_flag, ovf_flag and run_sts at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | NUM_EVT | Peripheral event lines, index = selector value |
| cfg_wr | input | 1 | Load strobe for the configuration fields |
| cfg_sel | input | $clog2(NUM_EVT) | Event selector, 0 = none |
| cfg_trig_en | input | 1 | Hardware trigger enable |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| cmd_wr | input | 1 | Command write strobe |
| cmd_force | input | 1 | Set the pending flag |
| cmd_clear | input | 1 | Clear the pending flag |
| cmd_run | input | 1 | Start the channel |
| cmd_halt | input | 1 | Stop the channel |
| cmd_soft_rst | input | 1 | Return the channel to idle |
| cmd_err_clr | input | 1 | Clear the overflow flag |
| seq_ack | input | 1 | Sequencer burst-start acknowledge |
| start_req | output | 1 | Service request to the sequencer |
| pend_flag | output | 1 | Pending trigger flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt |
| run_sts | output | 1 | Channel run status |

## Verification
The bench builds the block with NUM_EVT = 16, which gives a 4-bit selector. With that width, selector 0, a mid-range line and a line that is not selected can all be driven directly, so the bench can show that only the chosen line counts. The collision cases run at that size: trigger with acknowledge, trigger with clear, overflow with error-clear, and run with halt. Each of these has a defined winner.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
    // One-shot command bits, already qualified by the command strobe.
    typedef struct packed {
        logic force_set;
        logic clear;
        logic run;
        logic halt;
        logic soft_rst;
        logic err_clr;
    } cmd_t;

    // Sticky flag state of the channel.
    typedef struct packed {
        logic pend;
        logic ovf;
        logic ovf_ie;
    } flag_st_t;
endpackage

// File: rtl/dma_trig_select.sv
module dma_trig_select #(
    parameter int NUM_EVT = 256,
    parameter int SEL_W   = $clog2(NUM_EVT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               cfg_wr,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               cfg_trig_en,
    output logic               hw_trig
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
        logic             prev;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic    cur_lvl;

    always_comb begin
        // Selector 0 stands for "no peripheral".
        cur_lvl  = (st_q.sel != '0) ? evt_in[st_q.sel] : 1'b0;
        hw_trig  = st_q.en & cur_lvl & ~st_q.prev;
        st_d      = st_q;
        st_d.prev = cur_lvl;
        if (cfg_wr) begin
            st_d.sel = cfg_sel;
            st_d.en  = cfg_trig_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: selector zero never produces a hardware trigger
    assert_sel_zero_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == '0) |-> !hw_trig);

    // R5: a held level gives one trigger only
    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_trig && !cfg_wr) |=> !hw_trig);
endmodule

// File: rtl/dma_trig_flags.sv
module dma_trig_flags
    import dma_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_ovf_ie,
    input  logic hw_trig,
    input  cmd_t cmd,
    input  logic seq_ack,
    output logic pend,
    output logic ovf,
    output logic ovf_irq
);
    flag_st_t fl_d, fl_q;
    logic     trig;
    logic     ovf_set;

    always_comb begin
        trig    = hw_trig | cmd.force_set;
        ovf_set = trig & fl_q.pend & ~seq_ack & ~cmd.clear;
        fl_d    = fl_q;
        if (cfg_wr) fl_d.ovf_ie = cfg_ovf_ie;

        if (cmd.soft_rst)   fl_d.pend = 1'b0;
        else if (cmd.clear) fl_d.pend = 1'b0;
        else if (trig)      fl_d.pend = 1'b1;
        else if (seq_ack)   fl_d.pend = 1'b0;

        if (cmd.soft_rst)     fl_d.ovf = 1'b0;
        else if (ovf_set)     fl_d.ovf = 1'b1;
        else if (cmd.err_clr) fl_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign pend    = fl_q.pend;
    assign ovf     = fl_q.ovf;
    assign ovf_irq = fl_q.ovf & fl_q.ovf_ie;

    // R7: overflow only ever rises on top of an already pending trigger
    assert_ovf_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.ovf) |-> $past(fl_q.pend));

    // R10: an acknowledge without a new trigger consumes the pending flag
    assert_ack_consumes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_ack && !hw_trig && !cmd.force_set) |=> !fl_q.pend);

    // R11: soft reset empties both flags
    assert_soft_rst_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.soft_rst |=> (!fl_q.pend && !fl_q.ovf));
endmodule

// File: rtl/dma_trig_run.sv
module dma_trig_run
    import dma_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd,
    input  logic pend,
    output logic run_sts,
    output logic start_req
);
    logic run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (cmd.soft_rst || cmd.halt) run_d = 1'b0;
        else if (cmd.run)             run_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign run_sts   = run_q;
    assign start_req = run_q & pend;

    // R9: halt always stops the channel, even with run in the same write
    assert_halt_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.halt |=> !run_q);
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
    import dma_trig_pkg::*;
#(
    parameter int NUM_EVT = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_EVT-1:0]         evt_in,
    input  logic                       cfg_wr,
    input  logic [$clog2(NUM_EVT)-1:0] cfg_sel,
    input  logic                       cfg_trig_en,
    input  logic                       cfg_ovf_ie,
    input  logic                       cmd_wr,
    input  logic                       cmd_force,
    input  logic                       cmd_clear,
    input  logic                       cmd_run,
    input  logic                       cmd_halt,
    input  logic                       cmd_soft_rst,
    input  logic                       cmd_err_clr,
    input  logic                       seq_ack,
    output logic                       start_req,
    output logic                       pend_flag,
    output logic                       ovf_flag,
    output logic                       ovf_irq,
    output logic                       run_sts
);
    localparam int SEL_W = $clog2(NUM_EVT);

    cmd_t cmd;
    logic hw_trig;

    always_comb begin
        cmd.force_set = cmd_wr & cmd_force;
        cmd.clear     = cmd_wr & cmd_clear;
        cmd.run       = cmd_wr & cmd_run;
        cmd.halt      = cmd_wr & cmd_halt;
        cmd.soft_rst  = cmd_wr & cmd_soft_rst;
        cmd.err_clr   = cmd_wr & cmd_err_clr;
    end

    dma_trig_select #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_trig_en(cfg_trig_en), .hw_trig(hw_trig)
    );

    dma_trig_flags u_flags (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ovf_ie(cfg_ovf_ie),
        .hw_trig(hw_trig), .cmd(cmd), .seq_ack(seq_ack),
        .pend(pend_flag), .ovf(ovf_flag), .ovf_irq(ovf_irq)
    );

    dma_trig_run u_run (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .pend(pend_flag),
        .run_sts(run_sts), .start_req(start_req)
    );

    // R10: a request is never raised for a stopped channel
    assert_req_only_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd.halt) |-> !start_req);
endmodule

// File: tb/tb_dma_trig_ctrl.sv
module tb_dma_trig_ctrl;
    localparam int NE = 16;
    localparam int SW = $clog2(NE);

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NE-1:0] evt_in = '0;
    logic          cfg_wr = 0, cfg_trig_en = 0, cfg_ovf_ie = 0;
    logic [SW-1:0] cfg_sel = '0;
    logic          cmd_wr = 0, cmd_force = 0, cmd_clear = 0, cmd_run = 0;
    logic          cmd_halt = 0, cmd_soft_rst = 0, cmd_err_clr = 0, seq_ack = 0;
    logic          start_req, pend_flag, ovf_flag, ovf_irq, run_sts;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_trig_ctrl #(.NUM_EVT(NE)) dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_trig_en(cfg_trig_en), .cfg_ovf_ie(cfg_ovf_ie),
        .cmd_wr(cmd_wr), .cmd_force(cmd_force), .cmd_clear(cmd_clear),
        .cmd_run(cmd_run), .cmd_halt(cmd_halt), .cmd_soft_rst(cmd_soft_rst),
        .cmd_err_clr(cmd_err_clr), .seq_ack(seq_ack), .start_req(start_req),
        .pend_flag(pend_flag), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq),
        .run_sts(run_sts)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg(input int sel, input logic en, input logic ie);
        cfg_wr = 1; cfg_sel = SW'(sel); cfg_trig_en = en; cfg_ovf_ie = ie;
        step();
        cfg_wr = 0;
    endtask

    // force, clear, run, halt, soft reset, error clear, ack
    task automatic cmd(input logic f, input logic c, input logic r, input logic h,
                       input logic s, input logic e, input logic a);
        cmd_wr = 1; cmd_force = f; cmd_clear = c; cmd_run = r; cmd_halt = h;
        cmd_soft_rst = s; cmd_err_clr = e; seq_ack = a;
        step();
        cmd_wr = 0; cmd_force = 0; cmd_clear = 0; cmd_run = 0; cmd_halt = 0;
        cmd_soft_rst = 0; cmd_err_clr = 0; seq_ack = 0;
    endtask

    task automatic pulse(input int idx);
        evt_in[idx] = 1; step();
        evt_in[idx] = 0; step();
    endtask

    task automatic t_reset();
        check("R1", "pend", pend_flag, 0);
        check("R1", "ovf", ovf_flag, 0);
        check("R1", "irq", ovf_irq, 0);
        check("R1", "run", run_sts, 0);
        check("R1", "req", start_req, 0);
    endtask

    task automatic t_select();
        cfg(5, 1, 1);
        evt_in[3] = 1; step(); evt_in[3] = 0; step();
        check("R2", "other line ignored", pend_flag, 0);
        evt_in[5] = 1; step();
        check("R2", "edge sets pend", pend_flag, 1);
        check("R10", "no req while stopped", start_req, 0);
        step(); step(); step();
        check("R5", "held level no overflow", ovf_flag, 0);
        cmd(0, 1, 0, 0, 0, 0, 0);
        check("R6", "clear drops pend", pend_flag, 0);
        step();
        check("R5", "held level no retrigger", pend_flag, 0);
        evt_in[5] = 0; step();
        evt_in[5] = 1; step();
        check("R2", "second edge sets pend", pend_flag, 1);
        evt_in[5] = 0;
        cmd(0, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_gating();
        cfg(5, 0, 0);
        pulse(5);
        check("R4", "disabled trigger", pend_flag, 0);
        cfg(0, 1, 0);
        pulse(0);
        check("R3", "selector zero ignores line 0", pend_flag, 0);
        cmd(1, 0, 0, 0, 0, 0, 0);
        check("R3", "force with selector zero", pend_flag, 1);
        cmd(0, 0, 0, 0, 0, 0, 0);
        check("R6", "zero write keeps pend", pend_flag, 1);
        check("R6", "zero write no run", run_sts, 0);
        cmd(0, 1, 0, 0, 0, 0, 0);
        check("R6", "clear after force", pend_flag, 0);
    endtask

    task automatic t_overflow();
        cfg(7, 1, 0);
        pulse(7);
        check("R7", "first trigger pend", pend_flag, 1);
        check("R7", "first trigger no ovf", ovf_flag, 0);
        pulse(7);
        check("R7", "second trigger ovf", ovf_flag, 1);
        check("R7", "irq masked", ovf_irq, 0);
        cfg(7, 1, 1);
        check("R7", "irq enabled", ovf_irq, 1);
        cmd(0, 0, 0, 0, 0, 1, 0);
        check("R8", "err clear", ovf_flag, 0);
        check("R8", "irq follows", ovf_irq, 0);
        check("R8", "err clear keeps pend", pend_flag, 1);
        cmd(1, 0, 0, 0, 0, 1, 0);
        check("R8", "new overflow beats err clear", ovf_flag, 1);
        cmd(0, 0, 0, 0, 0, 1, 0);
        check("R8", "err clear again", ovf_flag, 0);
    endtask

    task automatic t_run();
        cmd(0, 0, 1, 0, 0, 0, 0);
        check("R9", "run sets status", run_sts, 1);
        check("R10", "req with run and pend", start_req, 1);
        seq_ack = 1; step(); seq_ack = 0;
        check("R10", "ack clears pend", pend_flag, 0);
        check("R10", "req drops", start_req, 0);
        cmd(1, 0, 0, 0, 0, 0, 0);
        cmd(1, 0, 0, 0, 0, 0, 1);
        check("R10", "trigger with ack stays pending", pend_flag, 1);
        check("R10", "trigger with ack no ovf", ovf_flag, 0);
        cmd(1, 1, 0, 0, 0, 0, 0);
        check("R6", "clear beats force", pend_flag, 0);
        check("R6", "clear beats force no ovf", ovf_flag, 0);
        cmd(0, 0, 1, 1, 0, 0, 0);
        check("R9", "halt beats run", run_sts, 0);
        cmd(0, 0, 1, 0, 0, 0, 0);
        cmd(0, 0, 0, 1, 0, 0, 0);
        check("R9", "halt stops", run_sts, 0);
    endtask

    task automatic t_soft();
        cfg(7, 1, 1);
        cmd(1, 0, 1, 0, 0, 0, 0);
        pulse(7);
        check("R11", "setup ovf", ovf_flag, 1);
        check("R11", "setup req", start_req, 1);
        cmd(0, 0, 0, 0, 1, 0, 0);
        check("R11", "pend cleared", pend_flag, 0);
        check("R11", "ovf cleared", ovf_flag, 0);
        check("R11", "run cleared", run_sts, 0);
        check("R11", "irq cleared", ovf_irq, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_select();
        t_gating();
        t_overflow();
        t_run();
        t_soft();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule